// File: doc/BRIEF.md
# Chroma Horizontal Downsampler

This streaming block takes YCbCr 4:4:4 pixels, at most one per clock, each marked valid and the first of every line flagged as start of line. It halves the horizontal chroma rate. Every luma sample is kept. Chroma comes out as one Cb/Cr pair per two input pixels. Each output beat carries an even pixel's luma, the following odd pixel's luma and the pair's decimated chroma. Four decimation methods can be chosen at run time. A downscale enable switches the method off completely, so pixels pass through one per beat. All output components are clamped and may be reduced to 8 bits.

The line width is a configuration value. Pixels past it are discarded, and the final pair of an odd-width line is formed with edge replication. The configuration is captured with each start-of-line pixel, so software can change it at any time without corrupting a line in flight. A block-enable output reports whether any downscale direction is switched on.

Top module: `chroma_hdown`

## Requirements
- R1: While reset is held and right after it, `o_vld` and `o_blk_en` are 0.
- R2: Method code 0 (drop) outputs the chroma of the even pixel of each pair. Code 1 (average) outputs (c0+c1+1)>>1 of the even and odd pixel.
- R3: Method code 2 (co-sited) outputs (c[2k-1]+2*c[2k]+c[2k+1]+2)>>2 for pair k. Indices outside the line are replaced by the nearest edge pixel.
- R4: Method code 3 (off-sited) outputs (c[2k-1]+3*c[2k]+3*c[2k+1]+c[2k+2]+4)>>3 for pair k, with the same edge replication.
- R5: With `cfg_h_en`=0 each accepted pixel gives one beat with its own luma in `o_y0` and `o_y1`, its unchanged chroma, and `o_two`=0.
- R6: `o_blk_en` equals `cfg_h_en | cfg_v_en` of the previous cycle.
- R7: With the depth bit at 0 the components are 10-bit values clamped to 0..0x3FF. With the depth bit at 1 each component becomes min((v+2)>>2, 255), and the upper bits are zero.
- R8: Pixels at index >= the line width, and pixels before the first start of line, produce no output. A width of 0 produces no output for that line.
- R9: An odd width W emits a final beat for the pixel at index W-1. That beat has `o_two`=0, `o_y1`=`o_y0`, and chroma computed with edge replication.
- R10: Method, enable, depth and width are sampled with the start-of-line pixel and held for the rest of that line.
- R11: A downscaled beat for pair k is triggered by accepting pixel 2k+2, or by the line's last pixel if that comes first. A beat appears in the cycle after its trigger. If two beats become due in the same cycle, the second follows one cycle later, and beat order always matches trigger order.
- R12: In a full downscaled beat, `o_two`=1, `o_y0` is the luma of pixel 2k and `o_y1` is the luma of pixel 2k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_en | input | 1 | Horizontal downscale enable; 0 bypasses the method |
| cfg_v_en | input | 1 | Vertical downscale enable; only feeds the block enable |
| cfg_method | input | 2 | 0 drop, 1 average, 2 co-sited, 3 off-sited |
| cfg_depth8 | input | 1 | 0: 10-bit output, 1: 8-bit output |
| cfg_width | input | WW | Line width in pixels |
| in_vld | input | 1 | Input pixel valid |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_y | input | DW | Input luma |
| in_cb | input | DW | Input blue-difference chroma |
| in_cr | input | DW | Input red-difference chroma |
| o_vld | output | 1 | Output beat valid |
| o_two | output | 1 | Beat holds two luma samples |
| o_y0 | output | DW | Luma of the even (or only) pixel |
| o_y1 | output | DW | Luma of the odd pixel (copy of o_y0 if o_two is 0) |
| o_cb | output | DW | Output Cb |
| o_cr | output | DW | Output Cr |
| o_blk_en | output | 1 | Any downscale direction enabled |

## Verification
Two beats can come due in the same cycle. The first is the deferred final pair of an odd-width line. The second is whatever the next line emits on its first pixel: a bypassed pixel, or the single pair of a width-1 line. The bench provokes this by sending an odd-width line and, with no idle cycle, a bypass line, and then a width-1 line. A behavioural model queues every expected beat with the cycle of its trigger. Each output beat is compared in value and order, and must arrive one or two cycles after its trigger. Nothing may be left in the queue at the end.

// File: rtl/chd_pkg.sv
package chd_pkg;

  // Decimation method codes
  typedef enum logic [1:0] {
    CHD_DROP    = 2'd0,
    CHD_AVG     = 2'd1,
    CHD_COSITE  = 2'd2,
    CHD_OFFSITE = 2'd3
  } chd_method_e;

  // Per-line operating mode captured at start of line
  typedef struct packed {
    logic        h_en;
    chd_method_e method;
    logic        depth8;
  } chd_mode_t;

endpackage

// File: rtl/chd_filter.sv
module chd_filter
  import chd_pkg::*;
#(
  parameter int DW = 10
) (
  input  chd_method_e   method,
  input  logic [DW-1:0] l,
  input  logic [DW-1:0] e,
  input  logic [DW-1:0] o,
  input  logic [DW-1:0] r,
  output logic [DW-1:0] f
);
  localparam int SW = DW + 3;

  logic [SW-1:0] le, ee, oe, re;
  logic [SW-1:0] s_avg, s_co, s_off;

  always_comb begin
    le    = SW'(l);
    ee    = SW'(e);
    oe    = SW'(o);
    re    = SW'(r);
    s_avg = (ee + oe + SW'(1)) >> 1;
    s_co  = (le + (ee << 1) + oe + SW'(2)) >> 2;
    s_off = (le + (ee << 1) + ee + (oe << 1) + oe + re + SW'(4)) >> 3;
    case (method)
      CHD_DROP:    f = e;
      CHD_AVG:     f = s_avg[DW-1:0];
      CHD_COSITE:  f = s_co[DW-1:0];
      default:     f = s_off[DW-1:0];
    endcase
  end

endmodule

// File: rtl/chd_quant.sv
module chd_quant #(
  parameter int DW  = 10,
  parameter int LIM = (1 << DW) - 1
) (
  input  logic [DW-1:0] v,
  input  logic          depth8,
  output logic [DW-1:0] q
);
  localparam int          NW   = DW - 2;
  localparam logic [DW-1:0] HI   = DW'(LIM);
  localparam logic [DW:0]   NMAX = (DW+1)'((1 << NW) - 1);

  logic [DW-1:0] clamped;
  logic [DW:0]   rnd;

  always_comb begin
    clamped = (v > HI) ? HI : v;
    rnd     = ({1'b0, clamped} + (DW+1)'(2)) >> 2;
    if (depth8) begin
      q = (rnd > NMAX) ? NMAX[DW-1:0] : rnd[DW-1:0];
    end else begin
      q = clamped;
    end
  end

endmodule

// File: rtl/chd_linectl.sv
module chd_linectl
  import chd_pkg::*;
#(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_sol,
  input  chd_mode_t     cfg_mode,
  input  logic [WW-1:0] cfg_width,
  output logic          acc,
  output logic          first,
  output logic          even,
  output logic          last,
  output chd_mode_t     cur_mode
);
  logic [WW-1:0] idx_q, idx_d;
  logic [WW-1:0] wid_q, wid_d;
  chd_mode_t     mode_q, mode_d;
  logic          act_q, act_d;
  logic [WW-1:0] cur_idx, w_eff;
  logic          ld;

  always_comb begin
    ld       = in_vld & in_sol;
    cur_idx  = in_sol ? '0 : idx_q;
    w_eff    = in_sol ? cfg_width : wid_q;
    cur_mode = in_sol ? cfg_mode : mode_q;
    acc      = in_vld & (in_sol | act_q) & (cur_idx < w_eff);
    first    = (cur_idx == '0);
    even     = ~cur_idx[0];
    last     = acc & (cur_idx == (w_eff - WW'(1)));
  end

  always_comb begin
    idx_d  = idx_q;
    wid_d  = wid_q;
    mode_d = mode_q;
    act_d  = act_q;
    if (ld) begin
      act_d  = 1'b1;
      wid_d  = cfg_width;
      mode_d = cfg_mode;
      idx_d  = acc ? WW'(1) : '0;
    end else if (acc) begin
      idx_d  = idx_q + WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      wid_q  <= '0;
      mode_q <= '0;
      act_q  <= 1'b0;
    end else begin
      if (ld | acc) idx_q <= idx_d;
      if (ld) begin
        wid_q  <= wid_d;
        mode_q <= mode_d;
        act_q  <= act_d;
      end
    end
  end

  // R8
  past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last) |=> (in_sol || !acc));

endmodule

// File: rtl/chroma_hdown.sv
module chroma_hdown
  import chd_pkg::*;
#(
  parameter int DW = 10,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_h_en,
  input  logic          cfg_v_en,
  input  logic [1:0]    cfg_method,
  input  logic          cfg_depth8,
  input  logic [WW-1:0] cfg_width,
  input  logic          in_vld,
  input  logic          in_sol,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  output logic          o_vld,
  output logic          o_two,
  output logic [DW-1:0] o_y0,
  output logic [DW-1:0] o_y1,
  output logic [DW-1:0] o_cb,
  output logic [DW-1:0] o_cr,
  output logic          o_blk_en
);
  localparam int NC = 2;          // chroma components
  localparam int NQ = 4;          // components per beat
  localparam int BW = 1 + NQ * DW; // packed beat width

  chd_mode_t cfg_mode_w, cur_mode;
  logic      acc, first, even, last;

  assign cfg_mode_w = '{h_en: cfg_h_en, method: chd_method_e'(cfg_method), depth8: cfg_depth8};

  chd_linectl #(.WW(WW)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_sol   (in_sol),
    .cfg_mode (cfg_mode_w),
    .cfg_width(cfg_width),
    .acc      (acc),
    .first    (first),
    .even     (even),
    .last     (last),
    .cur_mode (cur_mode)
  );

  // Sliding window registers
  logic [NC-1:0][DW-1:0] new_c, prv_q, ev_q, od_q;
  logic [DW-1:0]         ev_y_q, od_y_q;
  logic                  ld_ev, ld_od;

  assign new_c = {in_cr, in_cb};
  assign ld_ev = acc & even;
  assign ld_od = acc & ~even;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q  <= '0;
      ev_q   <= '0;
      od_q   <= '0;
      ev_y_q <= '0;
      od_y_q <= '0;
    end else begin
      if (ld_ev) begin
        ev_q   <= new_c;
        ev_y_q <= in_y;
        prv_q  <= first ? new_c : od_q;
      end
      if (ld_od) begin
        od_q   <= new_c;
        od_y_q <= in_y;
      end
    end
  end

  // Candidate beats
  logic hen, main_v, tnow_v, byp_v, b_vld, c_vld;

  always_comb begin
    hen    = cur_mode.h_en;
    main_v = acc & hen & ((even & ~first) | (~even & last));
    tnow_v = acc & hen & even & last & first;
    byp_v  = acc & ~hen;
    b_vld  = main_v | tnow_v | byp_v;
    c_vld  = acc & hen & even & last & ~first;
  end

  logic [NC-1:0][DW-1:0] main_f, tail_f;

  for (genvar g = 0; g < NC; g++) begin : g_comp
    chd_filter #(.DW(DW)) u_main (
      .method(cur_mode.method),
      .l     (prv_q[g]),
      .e     (ev_q[g]),
      .o     (even ? od_q[g] : new_c[g]),
      .r     (new_c[g]),
      .f     (main_f[g])
    );
    chd_filter #(.DW(DW)) u_tail (
      .method(cur_mode.method),
      .l     (first ? new_c[g] : od_q[g]),
      .e     (new_c[g]),
      .o     (new_c[g]),
      .r     (new_c[g]),
      .f     (tail_f[g])
    );
  end

  // Raw component sets: 0 y0, 1 y1, 2 cb, 3 cr
  logic [NQ-1:0][DW-1:0] raw_b, raw_c, qb, qc;

  always_comb begin
    if (main_v) begin
      raw_b[0] = ev_y_q;
      raw_b[1] = even ? od_y_q : in_y;
      raw_b[2] = main_f[0];
      raw_b[3] = main_f[1];
    end else if (tnow_v) begin
      raw_b[0] = in_y;
      raw_b[1] = in_y;
      raw_b[2] = tail_f[0];
      raw_b[3] = tail_f[1];
    end else begin
      raw_b[0] = in_y;
      raw_b[1] = in_y;
      raw_b[2] = in_cb;
      raw_b[3] = in_cr;
    end
    raw_c[0] = in_y;
    raw_c[1] = in_y;
    raw_c[2] = tail_f[0];
    raw_c[3] = tail_f[1];
  end

  for (genvar q = 0; q < NQ; q++) begin : g_quant
    chd_quant #(.DW(DW)) u_qb (.v(raw_b[q]), .depth8(cur_mode.depth8), .q(qb[q]));
    chd_quant #(.DW(DW)) u_qc (.v(raw_c[q]), .depth8(cur_mode.depth8), .q(qc[q]));
  end

  logic [BW-1:0] beat_b, beat_c;
  assign beat_b = {main_v, qb[0], qb[1], qb[2], qb[3]};
  assign beat_c = {1'b0,   qc[0], qc[1], qc[2], qc[3]};

  // Output register and one-deep pending slot
  logic [BW-1:0] out_q, out_d, pend_q, pend_d;
  logic          ovld_q, ovld_d, pvld_q, pvld_d;

  always_comb begin
    out_d  = out_q;
    pend_d = pend_q;
    ovld_d = 1'b0;
    pvld_d = 1'b0;
    if (pvld_q) begin
      out_d  = pend_q;
      ovld_d = 1'b1;
      pend_d = b_vld ? beat_b : beat_c;
      pvld_d = b_vld | c_vld;
    end else if (b_vld) begin
      out_d  = beat_b;
      ovld_d = 1'b1;
      pend_d = beat_c;
      pvld_d = c_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      pend_q   <= '0;
      ovld_q   <= 1'b0;
      pvld_q   <= 1'b0;
      o_blk_en <= 1'b0;
    end else begin
      ovld_q   <= ovld_d;
      pvld_q   <= pvld_d;
      o_blk_en <= cfg_h_en | cfg_v_en;
      if (ovld_d) out_q  <= out_d;
      if (pvld_d) pend_q <= pend_d;
    end
  end

  assign o_vld = ovld_q;
  assign o_two = out_q[BW-1];
  assign o_y0  = out_q[4*DW-1 -: DW];
  assign o_y1  = out_q[3*DW-1 -: DW];
  assign o_cb  = out_q[2*DW-1 -: DW];
  assign o_cr  = out_q[DW-1:0];

  // R11
  no_triple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pvld_q && b_vld && c_vld));

  // R9
  tail_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |=> pvld_q);

  // R11
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pvld_q |=> o_vld);

  // R5
  byp_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_v |=> o_vld);

  // R12
  main_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_v |=> o_vld);

endmodule

// File: tb/chroma_hdown_tb_top.sv
module chroma_hdown_tb_top;
  localparam int DW = 10;
  localparam int WW = 16;
  localparam int MAXN = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_h_en = 1'b0, cfg_v_en = 1'b0, cfg_depth8 = 1'b0;
  logic [1:0]    cfg_method = 2'd0;
  logic [WW-1:0] cfg_width = '0;
  logic          in_vld = 1'b0, in_sol = 1'b0;
  logic [DW-1:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic          o_vld, o_two, o_blk_en;
  logic [DW-1:0] o_y0, o_y1, o_cb, o_cr;

  chroma_hdown #(.DW(DW), .WW(WW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_en(cfg_h_en), .cfg_v_en(cfg_v_en), .cfg_method(cfg_method),
    .cfg_depth8(cfg_depth8), .cfg_width(cfg_width),
    .in_vld(in_vld), .in_sol(in_sol), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .o_vld(o_vld), .o_two(o_two), .o_y0(o_y0), .o_y1(o_y1),
    .o_cb(o_cb), .o_cr(o_cr), .o_blk_en(o_blk_en)
  );

  always #10 clk = ~clk; // 50 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    y0, y1, cb, cr, two, stamp;
    string tag;
  } exp_t;
  exp_t expq[$];

  int ny[MAXN], ncb[MAXN], ncr[MAXN];

  function automatic int q8(int v, int d8);
    int r;
    if (v > 1023) v = 1023;
    if (!d8) return v;
    r = (v + 2) >> 2;
    return (r > 255) ? 255 : r;
  endfunction

  function automatic int cat(int comp, int i, int w);
    if (i < 0) i = 0;
    if (i > w - 1) i = w - 1;
    return comp ? ncr[i] : ncb[i];
  endfunction

  function automatic int filt(int m, int comp, int k, int w);
    int l, e, o, r;
    l = cat(comp, 2*k-1, w);
    e = cat(comp, 2*k, w);
    o = cat(comp, 2*k+1, w);
    r = cat(comp, 2*k+2, w);
    case (m)
      0: return e;                                 // R2 drop
      1: return (e + o + 1) >> 1;                  // R2 average
      2: return (l + 2*e + o + 2) >> 2;            // R3
      default: return (l + 3*e + 3*o + r + 4) >> 3; // R4
    endcase
  endfunction

  task automatic push(int y0, int y1, int cb, int cr, int two, string tag);
    exp_t x;
    x.y0 = y0; x.y1 = y1; x.cb = cb; x.cr = cr; x.two = two;
    x.stamp = cyc; x.tag = tag;
    expq.push_back(x);
  endtask

  // Expected beats triggered by accepting pixel j
  task automatic expect_at(int j, int hen, int m, int d8, int w, string tag);
    if (!hen) begin
      push(q8(ny[j], d8), q8(ny[j], d8), q8(ncb[j], d8), q8(ncr[j], d8), 0, {tag, " R5"});
    end else begin
      for (int k = 0; k < (w + 1) / 2; k++) begin
        int trig, two;
        trig = (2*k+2 <= w-1) ? 2*k+2 : w-1; // R11
        if (trig == j) begin
          two = (2*k+1 <= w-1);
          push(q8(ny[2*k], d8), q8(two ? ny[2*k+1] : ny[2*k], d8),
               q8(filt(m, 0, k, w), d8), q8(filt(m, 1, k, w), d8), two,
               two ? {tag, " R12"} : {tag, " R9"});
        end
      end
    end
  endtask

  task automatic fill_rand();
    for (int i = 0; i < MAXN; i++) begin
      ny[i] = $urandom_range(0, 1023);
      ncb[i] = $urandom_range(0, 1023);
      ncr[i] = $urandom_range(0, 1023);
    end
  endtask

  task automatic fill_hi();
    for (int i = 0; i < MAXN; i++) begin
      ny[i] = 1022 + (i % 2);
      ncb[i] = 1023;
      ncr[i] = 1020 + (i % 4);
    end
  endtask

  // Drive a line starting one unit after a rising edge
  task automatic send_line(int hen, int m, int d8, int w, int n, int gaps, int idle, string tag);
    for (int j = 0; j < n; j++) begin
      in_vld = 1'b1;
      in_sol = (j == 0);
      in_y = DW'(ny[j]); in_cb = DW'(ncb[j]); in_cr = DW'(ncr[j]);
      if (j == 0) begin
        cfg_h_en = hen[0]; cfg_method = m[1:0]; cfg_depth8 = d8[0]; cfg_width = WW'(w);
      end else begin
        // R10: scrambled mid-line settings must be ignored
        cfg_h_en = ~hen[0]; cfg_method = ~m[1:0]; cfg_depth8 = ~d8[0]; cfg_width = WW'(w + 3);
      end
      if (j < w) expect_at(j, hen, m, d8, w, tag);
      @(posedge clk); #1;
      if (gaps != 0 && (j % 3) == 1) begin
        in_vld = 1'b0; in_sol = 1'b0;
        @(posedge clk); #1;
      end
    end
    in_vld = 1'b0; in_sol = 1'b0;
    repeat (idle) begin @(posedge clk); #1; end
  endtask

  // Output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && o_vld) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected beat: actual y0=%0d cb=%0d cr=%0d expected none",
                 o_y0, o_cb, o_cr);
      end else begin
        exp_t x;
        int d;
        x = expq.pop_front();
        d = cyc - x.stamp;
        if (o_y0 !== DW'(x.y0) || o_y1 !== DW'(x.y1) || o_cb !== DW'(x.cb) ||
            o_cr !== DW'(x.cr) || o_two !== x.two[0] || !(d == 1 || d == 2)) begin
          errors++;
          $display("FAIL %s R11: actual y0=%0d y1=%0d cb=%0d cr=%0d two=%0d lat=%0d expected y0=%0d y1=%0d cb=%0d cr=%0d two=%0d lat=1..2",
                   x.tag, o_y0, o_y1, o_cb, o_cr, o_two, d, x.y0, x.y1, x.cb, x.cr, x.two);
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 o_vld in reset", int'(o_vld), 0);
    chk("R1 o_blk_en in reset", int'(o_blk_en), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R1 o_vld after reset", int'(o_vld), 0);
    chk("R1 o_blk_en after reset", int'(o_blk_en), 0);

    // R6: block enable
    @(posedge clk); #1;
    cfg_v_en = 1'b1; cfg_h_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 v_en only", int'(o_blk_en), 1);
    #11; cfg_v_en = 1'b0; cfg_h_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R6 h_en only", int'(o_blk_en), 1);
    #11; cfg_h_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 none", int'(o_blk_en), 0);
    @(posedge clk); #1;

    // R8: pixels before the first start of line are ignored
    fill_rand();
    cfg_h_en = 1'b0; cfg_width = WW'(8);
    for (int j = 0; j < 3; j++) begin
      in_vld = 1'b1; in_sol = 1'b0; in_y = DW'(ny[j]); in_cb = DW'(ncb[j]); in_cr = DW'(ncr[j]);
      @(posedge clk); #1;
    end
    in_vld = 1'b0;
    repeat (3) begin @(posedge clk); #1; end

    // R2, R3, R4: each method, even width
    for (int m = 0; m < 4; m++) begin
      fill_rand();
      send_line(1, m, 0, 8, 8, 0, 2, (m < 2) ? "R2" : (m == 2) ? "R3" : "R4");
    end
    // R9: odd widths with gaps
    fill_rand(); send_line(1, 3, 0, 7, 7, 1, 2, "R9 R4");
    fill_rand(); send_line(1, 2, 0, 5, 5, 0, 2, "R9 R3");
    fill_rand(); send_line(1, 1, 0, 3, 3, 1, 2, "R9 R2");
    fill_rand(); send_line(1, 3, 0, 1, 1, 0, 2, "R9 R4");
    fill_rand(); send_line(1, 2, 0, 2, 2, 0, 2, "R3");
    // R5: bypass
    fill_rand(); send_line(0, 2, 0, 6, 6, 1, 2, "R5");
    // R7: 8-bit output with saturation
    fill_hi();   send_line(1, 3, 1, 6, 6, 0, 2, "R7");
    fill_hi();   send_line(0, 0, 1, 4, 4, 0, 2, "R7");
    fill_rand(); send_line(1, 1, 1, 9, 9, 0, 2, "R7");
    // R8: width 0 and pixels past the width
    fill_rand(); send_line(1, 0, 0, 0, 4, 0, 2, "R8");
    fill_rand(); send_line(1, 3, 0, 6, 10, 0, 2, "R8");
    // R11: truncated line then immediate new line
    fill_rand(); send_line(1, 2, 0, 8, 5, 0, 0, "R11");
    // R11: deferred tail collides with next line's first beat
    fill_rand(); send_line(1, 3, 0, 5, 5, 0, 0, "R11 R9");
    fill_rand(); send_line(0, 1, 0, 4, 4, 0, 0, "R11 R5");
    fill_rand(); send_line(1, 2, 0, 7, 7, 0, 0, "R11 R9");
    fill_rand(); send_line(1, 3, 1, 1, 1, 0, 0, "R11 R9");
    fill_rand(); send_line(1, 3, 0, 1, 1, 0, 4, "R11 R9");
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R11 leftover expected beats", expq.size(), 0);
  endtask

  bit timed_out = 1'b0;

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule